// File: doc/BRIEF.md
# SDRAM Power-Up and Command Spacing Sequencer

This block sits inside a small SDRAM controller, between the request arbiter and the SDRAM command pins. Once enabled, it waits out a programmable power-up delay and then brings the memory up by itself. It first precharges the banks, then issues a single auto-refresh, and then loads the mode register. After that it enters normal operation. It takes activate, refresh and precharge requests from the arbiter and turns each accepted request into a one-cycle command on the chip-select, row-strobe, column-strobe and write-enable lines. In every other cycle it drives a NOP.

Three spacing rules are enforced with a single down-counter. A 2-bit field sets how long an activate must wait after a mode load. A 3-bit field sets how long an activate (or the mode load during bring-up) must wait after a refresh. Another 3-bit field sets how long a precharge must wait after an activate. Each field is a raw count of controller clocks, and zero is a legal value. While bring-up runs or a spacing count is live, `ready` is low. A request held during that time is served as soon as `ready` returns, so no request is lost. Dropping `enable` returns the block to its reset state, and raising it again restarts the whole power-up sequence.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, and in every cycle after a clock edge that samples `enable` low, the command lines carry NOP, `ready` is low and `initDone` is low. Both configuration registers reset to zero.
- R2: With init delay D programmed, the first command after enable is a precharge. It appears exactly D+1 clock edges after the first edge that samples `enable` high, so D+1 NOP cycles come before it.
- R3: Bring-up issues precharge, then refresh on the very next cycle, then load-mode after exactly R NOP cycles, where R is the refresh field. No other command is issued during bring-up.
- R4: With a request already pending, an activate follows a load-mode after exactly M NOP cycles. M is the mode field, taken from bits 7:6 of the timing register.
- R5: During normal operation, a pending activate follows a refresh after exactly R NOP cycles. R is taken from bits 5:3 of the timing register.
- R6: A pending precharge follows an activate after exactly P NOP cycles. P is taken from bits 2:0 of the timing register.
- R7: `ready` is low during bring-up and while a spacing count is running. A request held through that time is issued once `ready` returns and is never dropped.
- R8: Clearing `enable` in any state aborts the current activity. Setting `enable` again repeats the full delay and bring-up sequence.
- R9: Command codes on {csN,rasN,casN,weN} are 0111 for NOP, 0011 for activate, 0010 for precharge, 0001 for refresh and 0000 for load-mode. At most one non-NOP command appears per cycle, and only for an accepted request or a bring-up step.
- R10: When several requests are pending as `ready` rises, refresh is served before precharge, and precharge before activate.
- R11: `initDone` rises in the same cycle as the load-mode command and stays high until `enable` is cleared.
- R12: A write with `cfgWrEn` high and `cfgSel`=1 loads the 14-bit init delay from `cfgWrData`. A write with `cfgSel`=0 loads the timing register from `cfgWrData[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Starts the sequencer; low forces the reset state |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects the timing register, 1 selects the init delay |
| cfgWrData | input | 14 | Configuration write data |
| reqAct | input | 1 | Activate request, held until issued |
| reqRef | input | 1 | Refresh request, held until issued |
| reqPre | input | 1 | Precharge request, held until issued |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| ready | output | 1 | High when a request can be issued at the next edge |
| initDone | output | 1 | Bring-up finished |

## Verification
The bench counts NOP cycles between every pair of commands for each value of every field, including zero. A design that miscounts by one would issue commands a cycle early or late. A design that ignores a zero setting would insert a stray NOP. The activate request is raised together with `enable`, so it waits through the whole bring-up. A sequencer that dropped early requests, or let them bypass the bring-up, would show a missing or misplaced activate. All three requests are also raised at once behind a live spacing count, which exposes a wrong priority or a precharge that ignores the refresh spacing. Finally, `enable` is dropped in the middle of the power-up wait. A design that resumed the old count instead of restarting would shorten the first gap.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_NOP = 4'b0111
  } sdCmd_e;

  typedef enum logic [1:0] {
    GAP_NONE,
    GAP_MODE,
    GAP_ROW,
    GAP_RAS
  } gapSel_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_POWERUP,
    ST_INITREF,
    ST_INITMODE,
    ST_RUN
  } seqState_e;

  typedef struct packed {
    logic    clearAll;
    logic    loadInit;
    logic    issue;
    sdCmd_e  cmd;
    gapSel_e gapSel;
  } seqStrobe_t;

endpackage

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int INIT_W = 14,
  parameter int MODE_W = 2,
  parameter int ROW_W  = 3,
  parameter int RAS_W  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfgWrEn,
  input  logic                            cfgSel,
  input  logic [INIT_W-1:0]               cfgWrData,
  input  seqStrobe_t                      strobe,
  output logic                            cntZero,
  output logic [MODE_W+ROW_W+RAS_W-1:0]   timCfg,
  output logic [3:0]                      cmdOut
);

  localparam int TIM_W  = MODE_W + ROW_W + RAS_W;
  localparam int ROW_LO = RAS_W;
  localparam int MODE_LO = RAS_W + ROW_W;

  logic [TIM_W-1:0]  timReg;
  logic [INIT_W-1:0] dlyReg;
  logic [INIT_W-1:0] cnt;
  logic [INIT_W-1:0] gapLoad;
  sdCmd_e            cmdReg;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timReg <= '0;
      dlyReg <= '0;
    end else if (cfgWrEn) begin
      if (cfgSel) dlyReg <= cfgWrData;
      else        timReg <= cfgWrData[TIM_W-1:0];
    end
  end

  // gap value selected by the issuing command
  always_comb begin
    unique case (strobe.gapSel)
      GAP_MODE: gapLoad = INIT_W'(timReg[MODE_LO +: MODE_W]);
      GAP_ROW:  gapLoad = INIT_W'(timReg[ROW_LO +: ROW_W]);
      GAP_RAS:  gapLoad = INIT_W'(timReg[RAS_W-1:0]);
      default:  gapLoad = '0;
    endcase
  end

  // shared wait counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (strobe.clearAll) begin
      cnt <= '0;
    end else if (strobe.loadInit) begin
      cnt <= dlyReg;
    end else if (strobe.issue) begin
      cnt <= gapLoad;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // registered command pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg <= CMD_NOP;
    end else if (strobe.clearAll || !strobe.issue) begin
      cmdReg <= CMD_NOP;
    end else begin
      cmdReg <= strobe.cmd;
    end
  end

  assign cntZero = (cnt == '0);
  assign timCfg  = timReg;
  assign cmdOut  = cmdReg;

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       cntZero,
  input  logic       reqAct,
  input  logic       reqRef,
  input  logic       reqPre,
  output seqStrobe_t strobe,
  output logic       ready,
  output logic       initDone
);

  seqState_e state, stateNxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= stateNxt;
  end

  always_comb begin
    stateNxt        = state;
    strobe.clearAll = 1'b0;
    strobe.loadInit = 1'b0;
    strobe.issue    = 1'b0;
    strobe.cmd      = CMD_NOP;
    strobe.gapSel   = GAP_NONE;
    if (!enable) begin
      stateNxt        = ST_OFF;
      strobe.clearAll = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: begin
          strobe.loadInit = 1'b1;
          stateNxt        = ST_POWERUP;
        end
        ST_POWERUP: begin
          if (cntZero) begin
            strobe.issue = 1'b1;
            strobe.cmd   = CMD_PRE;
            stateNxt     = ST_INITREF;
          end
        end
        ST_INITREF: begin
          strobe.issue  = 1'b1;
          strobe.cmd    = CMD_REF;
          strobe.gapSel = GAP_ROW;
          stateNxt      = ST_INITMODE;
        end
        ST_INITMODE: begin
          if (cntZero) begin
            strobe.issue  = 1'b1;
            strobe.cmd    = CMD_LMR;
            strobe.gapSel = GAP_MODE;
            stateNxt      = ST_RUN;
          end
        end
        ST_RUN: begin
          if (cntZero) begin
            if (reqRef) begin
              strobe.issue  = 1'b1;
              strobe.cmd    = CMD_REF;
              strobe.gapSel = GAP_ROW;
            end else if (reqPre) begin
              strobe.issue  = 1'b1;
              strobe.cmd    = CMD_PRE;
            end else if (reqAct) begin
              strobe.issue  = 1'b1;
              strobe.cmd    = CMD_ACT;
              strobe.gapSel = GAP_RAS;
            end
          end
        end
        default: stateNxt = ST_OFF;
      endcase
    end
  end

  assign initDone = (state == ST_RUN);
  assign ready    = enable && (state == ST_RUN) && cntZero;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_seq_pkg::*;
#(
  parameter int INIT_W = 14,
  parameter int MODE_W = 2,
  parameter int ROW_W  = 3,
  parameter int RAS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [INIT_W-1:0] cfgWrData,
  input  logic              reqAct,
  input  logic              reqRef,
  input  logic              reqPre,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              ready,
  output logic              initDone
);

  localparam int TIM_W = MODE_W + ROW_W + RAS_W;

  seqStrobe_t       strobe;
  logic             cntZero;
  logic [TIM_W-1:0] timCfg;
  logic [3:0]       cmdOut;

  sdram_seq_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .cntZero  (cntZero),
    .reqAct   (reqAct),
    .reqRef   (reqRef),
    .reqPre   (reqPre),
    .strobe   (strobe),
    .ready    (ready),
    .initDone (initDone)
  );

  sdram_seq_dp #(
    .INIT_W (INIT_W),
    .MODE_W (MODE_W),
    .ROW_W  (ROW_W),
    .RAS_W  (RAS_W)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .strobe    (strobe),
    .cntZero   (cntZero),
    .timCfg    (timCfg),
    .cmdOut    (cmdOut)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdOut;

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int MODE_W = 2,
  parameter int ROW_W  = 3,
  parameter int RAS_W  = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          enable,
  input logic                          ready,
  input logic                          initDone,
  input logic [3:0]                    cmd,
  input logic [MODE_W+ROW_W+RAS_W-1:0] timCfg
);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  logic [3:0] lastCmd;
  logic [7:0] gapCnt;
  logic [7:0] modeGap, rowGap, rasGap;

  assign rasGap  = 8'(timCfg[RAS_W-1:0]);
  assign rowGap  = 8'(timCfg[RAS_W +: ROW_W]);
  assign modeGap = 8'(timCfg[RAS_W+ROW_W +: MODE_W]);

  // history of observed pins: last command and NOPs since it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastCmd <= C_NOP;
      gapCnt  <= '0;
    end else if (!enable) begin
      lastCmd <= C_NOP;
      gapCnt  <= '0;
    end else if (cmd != C_NOP) begin
      lastCmd <= cmd;
      gapCnt  <= '0;
    end else if (gapCnt != 8'hFF) begin
      gapCnt  <= gapCnt + 1'b1;
    end
  end

  p_off_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cmd == C_NOP));
  p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!ready && !initDone));
  p_ready_needs_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> initDone);
  p_mode_after_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_LMR) |-> (lastCmd == C_REF && gapCnt >= rowGap));
  p_mode_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT && lastCmd == C_LMR) |-> (gapCnt >= modeGap));
  p_row_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT && lastCmd == C_REF) |-> (gapCnt >= rowGap));
  p_ras_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE && lastCmd == C_ACT) |-> (gapCnt >= rasGap));
  p_legal_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_NOP || cmd == C_ACT || cmd == C_PRE || cmd == C_REF || cmd == C_LMR));
  p_done_with_lmr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(initDone) |-> (cmd == C_LMR));

endmodule

bind sdram_init_seq sdram_seq_chk #(
  .MODE_W (MODE_W),
  .ROW_W  (ROW_W),
  .RAS_W  (RAS_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .ready    (ready),
  .initDone (initDone),
  .cmd      ({sdCsN, sdRasN, sdCasN, sdWeN}),
  .timCfg   (timCfg)
);

// File: tb/sdram_init_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic cfgWrEn = 1'b0;
  logic cfgSel = 1'b0;
  logic [13:0] cfgWrData = '0;
  logic reqAct = 1'b0, reqRef = 1'b0, reqPre = 1'b0;
  logic sdCsN, sdRasN, sdCasN, sdWeN, ready, initDone;
  logic [3:0] cmdBus;

  always #2.5 clk = ~clk;
  assign cmdBus = {sdCsN, sdRasN, sdCasN, sdWeN};

  sdram_init_seq dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .reqAct(reqAct), .reqRef(reqRef), .reqPre(reqPre),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .ready(ready), .initDone(initDone)
  );

  typedef struct {
    logic [3:0] cmd;
    int         gap;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  int nopCnt = 0;
  bit done = 1'b0;

  function automatic void check(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  function automatic void pushExp(logic [3:0] c, int g, string t);
    expItem_t it;
    it.cmd = c; it.gap = g; it.tag = t;
    expQ.push_back(it);
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // monitor: compare each issued command and its preceding NOP count
  always @(negedge clk) begin
    if (!rst_n || !enable) begin
      nopCnt = 0;
    end else if (cmdBus == C_NOP) begin
      nopCnt++;
    end else if (expQ.size() == 0) begin
      check(1'b0, "R9", "unexpected command", int'(cmdBus), int'(C_NOP));
      nopCnt = 0;
    end else begin
      expItem_t it;
      it = expQ.pop_front();
      check(cmdBus == it.cmd, it.tag, "command code", int'(cmdBus), int'(it.cmd));
      check(nopCnt == it.gap, it.tag, "NOP gap", nopCnt, it.gap);
      nopCnt = 0;
    end
  end

  task automatic nxt();
    @(negedge clk);
    #1;
  endtask

  task automatic cfgWrite(input logic sel, input logic [13:0] data);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    nxt();
    cfgWrEn = 1'b0;
  endtask

  task automatic waitCmd(input logic [3:0] c, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      nxt();
      if (cmdBus == c) begin seen = 1'b1; break; end
    end
    if (!seen) check(1'b0, tag, "command never seen", int'(C_NOP), int'(c));
  endtask

  task automatic checkOff(input string tag);
    check(cmdBus == C_NOP, tag, "pins not NOP", int'(cmdBus), int'(C_NOP));
    check(ready == 1'b0, tag, "ready while off", int'(ready), 0);
    check(initDone == 1'b0, tag, "initDone while off", int'(initDone), 0);
  endtask

  task automatic runCase(input int d, input int m, input int r, input int p, input bit writeCfg);
    enable = 1'b0;
    nxt();
    if (writeCfg) begin
      cfgWrite(1'b1, 14'(d));                               // R12 init delay
      cfgWrite(1'b0, {6'd0, 2'(m), 3'(r), 3'(p)});          // R12 timing fields
    end
    pushExp(C_PRE, d + 1, "R2");
    pushExp(C_REF, 0, "R3");
    pushExp(C_LMR, r, "R3");
    pushExp(C_ACT, m, "R4");
    enable = 1'b1;
    reqAct = 1'b1;                                          // R7 held through bring-up
    nxt();
    check(ready == 1'b0, "R7", "ready during bring-up", int'(ready), 0);
    waitCmd(C_ACT, "R7");
    reqAct = 1'b0;
    check(initDone == 1'b1, "R11", "initDone after load-mode", int'(initDone), 1);
    check(ready == (p == 0), "R7", "ready after activate", int'(ready), int'(p == 0));
    // R6 activate -> precharge
    pushExp(C_PRE, p, "R6");
    reqPre = 1'b1; waitCmd(C_PRE, "R6"); reqPre = 1'b0;
    pushExp(C_REF, 0, "R9");
    reqRef = 1'b1; waitCmd(C_REF, "R9"); reqRef = 1'b0;
    // R5 refresh -> activate
    pushExp(C_ACT, r, "R5");
    reqAct = 1'b1; waitCmd(C_ACT, "R5"); reqAct = 1'b0;
    // R10 all three pending behind the activate spacing
    pushExp(C_REF, p, "R10");
    pushExp(C_PRE, r, "R10");
    pushExp(C_ACT, 0, "R10");
    reqAct = 1'b1; reqRef = 1'b1; reqPre = 1'b1;
    waitCmd(C_REF, "R10"); reqRef = 1'b0;
    waitCmd(C_PRE, "R10"); reqPre = 1'b0;
    waitCmd(C_ACT, "R10"); reqAct = 1'b0;
    // R8 disable returns to reset state
    enable = 1'b0;
    nxt();
    checkOff("R8");
  endtask

  initial begin
    repeat (3) nxt();
    checkOff("R1");
    rst_n = 1'b1;
    nxt();
    checkOff("R1");
    // R1 zero defaults seen through the gaps
    runCase(0, 0, 0, 0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      runCase(i, i % 4, i, 7 - i, 1'b1);
    end
    runCase(37, 3, 7, 0, 1'b1);
    // R8 abort in the middle of the power-up wait, then full restart
    cfgWrite(1'b1, 14'd20);
    cfgWrite(1'b0, {6'd0, 2'd1, 3'd2, 3'd0});
    enable = 1'b1;
    repeat (6) nxt();
    enable = 1'b0;
    nxt();
    checkOff("R8");
    pushExp(C_PRE, 21, "R8");
    pushExp(C_REF, 0, "R8");
    pushExp(C_LMR, 2, "R8");
    enable = 1'b1;
    waitCmd(C_LMR, "R8");
    check(initDone == 1'b1, "R11", "initDone after restart", int'(initDone), 1);
    enable = 1'b0;
    nxt();
    checkOff("R1");
    repeat (3) nxt();
    check(expQ.size() == 0, "R9", "missing commands", expQ.size(), 0);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 1, 0);
    report();
  end

endmodule